// File: doc/BRIEF.md
# Power-Up Strap Latch Controller

This block sits beside a clock generator whose configuration pins do double duty. While the chip powers up, the block treats five shared pins as inputs. When the active-low power-good input first reads low, the block stores the pin levels once. It then waits a programmable number of reference clock cycles. After that wait it turns the pins into clock outputs through a direction control.

The stored straps hold a three-bit frequency code, a table choice and a test request. A register-source bit selects whether the frequency code and the table choice come from the stored straps or from register fields. A spread output is raised only when two separate register enables are both set. A high power-down input forces a low-power state at once, with no clock edge needed. While that state lasts, the sequencer and the strap store are frozen. The stored straps survive it and are never sampled again. A test request that was stored stays active until the synchronous reset, which stands for a full power cycle.

Top module: `strap_latch_ctrl`

## Requirements
- R1: After reset, strap_q is 0, pins_out_en is 0, test_mode is 0, freq_code is 0 and low_power is 0 (with pdown low).
- R2: Straps are captured on the first clock edge where pwrgd_n is low, the block is still waiting and low power is not active. The captured value shows on strap_q after that edge. Before such an edge, strap_q stays 0.
- R3: pins_out_en rises exactly POR_CYCLES clock edges after the capture edge, provided no power-down occurs. It then stays 1 until reset.
- R4: Once captured, strap_q ignores any later change on strap_pins or pwrgd_n.
- R5: Strap field positions are fixed: strap_pins[2:0] is the frequency code, strap_pins[3] is the table choice (0 = table A, 1 = table B) and strap_pins[4] is the test request.
- R6: test_mode equals the captured test bit. Once set, it stays set through power-down and pin changes, and only reset clears it.
- R7: With reg_src = 0, freq_code and table_sel come from strap_q. With reg_src = 1, they come from reg_fs and reg_tbl.
- R8: spread_en is 1 only when reg_ss_a and reg_ss_b are both 1.
- R9: pdown high sets low_power immediately, without waiting for a clock edge. low_power clears on the first clock edge at which pdown is low.
- R10: Every edge at which low_power is set is frozen: no capture happens and the power-up count does not advance. This stretches the output-enable delay by the frozen edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| pwrgd_n | input | 1 | Active-low power-good; low means the straps are valid |
| pdown | input | 1 | Asynchronous active-high power-down request |
| strap_pins | input | 5 | Raw levels on the shared pins |
| reg_src | input | 1 | Frequency source: 0 = straps, 1 = register |
| reg_fs | input | 3 | Register frequency code |
| reg_tbl | input | 1 | Register table choice |
| reg_ss_a | input | 1 | First spread enable |
| reg_ss_b | input | 1 | Second spread enable |
| strap_q | output | 5 | Captured straps |
| pins_out_en | output | 1 | 1 = shared pins drive clocks |
| freq_code | output | 3 | Selected frequency code |
| table_sel | output | 1 | Selected table |
| test_mode | output | 1 | Sticky test mode flag |
| spread_en | output | 1 | Effective spread enable |
| low_power | output | 1 | Low-power state active |

## Verification
Power-down and strap capture can both act on the same clock edge. The bench provokes this by holding pwrgd_n low with chosen pin levels while pdown is high. It then releases pdown and checks that strap_q stays 0 through the edge that clears low_power, and that the capture lands on the edge after it. A second case raises pdown in the middle of the power-up count. There the bench measures the number of edges until pins_out_en rises and compares it with the unfrozen count plus the frozen edges.

// File: rtl/strap_pkg.sv
`timescale 1ns/1ps
package strap_pkg;
    localparam int FS_W    = 3;
    localparam int STRAP_W = FS_W + 2;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_COUNT = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic            test;
        logic            tbl;
        logic [FS_W-1:0] fs;
    } strap_t;

    function automatic strap_t to_strap(input logic [STRAP_W-1:0] raw);
        return strap_t'(raw);
    endfunction

    function automatic logic pick_bit(input logic use_reg, input logic lat_b, input logic reg_b);
        return use_reg ? reg_b : lat_b;
    endfunction
endpackage

// File: rtl/lp_ctrl.sv
`timescale 1ns/1ps
module lp_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic pdown,
    output logic lp
);
    always_ff @(posedge clk or posedge pdown) begin
        if (pdown) begin
            lp <= 1'b1;
        end else if (rst) begin
            lp <= 1'b0;
        end else begin
            lp <= 1'b0;
        end
    end
endmodule

// File: rtl/strap_seq.sv
`timescale 1ns/1ps
module strap_seq
    import strap_pkg::*;
#(
    parameter int POR_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pwrgd_n,
    input  logic freeze,
    output logic capture,
    output logic out_en
);
    localparam int CNT_W = (POR_CYCLES > 1) ? $clog2(POR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POR_CYCLES - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    assign capture = (state_q == ST_WAIT) && !pwrgd_n && !freeze;
    assign out_en  = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
        end else if (!freeze) begin
            unique case (state_q)
                ST_WAIT: begin
                    if (capture) begin
                        state_q <= ST_COUNT;
                        cnt_q   <= '0;
                    end
                end
                ST_COUNT: begin
                    if (cnt_q == CNT_LAST) begin
                        state_q <= ST_RUN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/strap_capture.sv
`timescale 1ns/1ps
module strap_capture
    import strap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [STRAP_W-1:0] raw,
    output strap_t             q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (capture) begin
            q <= to_strap(raw);
        end
    end
endmodule

// File: rtl/freq_select.sv
`timescale 1ns/1ps
module freq_select
    import strap_pkg::*;
(
    input  strap_t          lat,
    input  logic            reg_src,
    input  logic [FS_W-1:0] reg_fs,
    input  logic            reg_tbl,
    input  logic            ss_a,
    input  logic            ss_b,
    output logic [FS_W-1:0] fs_out,
    output logic            tbl_out,
    output logic            ss_out
);
    for (genvar i = 0; i < FS_W; i++) begin : g_fs
        assign fs_out[i] = pick_bit(reg_src, lat.fs[i], reg_fs[i]);
    end
    assign tbl_out = pick_bit(reg_src, lat.tbl, reg_tbl);
    assign ss_out  = ss_a & ss_b;
endmodule

// File: rtl/strap_latch_ctrl.sv
`timescale 1ns/1ps
module strap_latch_ctrl
    import strap_pkg::*;
#(
    parameter int POR_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwrgd_n,
    input  logic               pdown,
    input  logic [STRAP_W-1:0] strap_pins,
    input  logic               reg_src,
    input  logic [FS_W-1:0]    reg_fs,
    input  logic               reg_tbl,
    input  logic               reg_ss_a,
    input  logic               reg_ss_b,
    output logic [STRAP_W-1:0] strap_q,
    output logic               pins_out_en,
    output logic [FS_W-1:0]    freq_code,
    output logic               table_sel,
    output logic               test_mode,
    output logic               spread_en,
    output logic               low_power
);
    logic   lp;
    logic   cap;
    strap_t lat;

    lp_ctrl u_lp (
        .clk   (clk),
        .rst   (rst),
        .pdown (pdown),
        .lp    (lp)
    );

    strap_seq #(.POR_CYCLES(POR_CYCLES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .pwrgd_n (pwrgd_n),
        .freeze  (lp),
        .capture (cap),
        .out_en  (pins_out_en)
    );

    strap_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .capture (cap),
        .raw     (strap_pins),
        .q       (lat)
    );

    freq_select u_sel (
        .lat     (lat),
        .reg_src (reg_src),
        .reg_fs  (reg_fs),
        .reg_tbl (reg_tbl),
        .ss_a    (reg_ss_a),
        .ss_b    (reg_ss_b),
        .fs_out  (freq_code),
        .tbl_out (table_sel),
        .ss_out  (spread_en)
    );

    assign strap_q   = lat;
    assign test_mode = lat.test;
    assign low_power = lp;
endmodule

// File: rtl/strap_latch_ctrl_chk.sv
`timescale 1ns/1ps
module strap_latch_ctrl_chk
    import strap_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               reg_src,
    input logic [STRAP_W-1:0] strap_q,
    input logic               pins_out_en,
    input logic [FS_W-1:0]    freq_code,
    input logic               test_mode,
    input logic               low_power
);
    // R3: once the pins drive clocks they stay that way until reset
    p_out_en_hold_r3: assert property (@(posedge clk) disable iff (rst)
        pins_out_en |=> pins_out_en);

    // R4: captured straps do not move after hand-over
    p_strap_stable_r4: assert property (@(posedge clk) disable iff (rst)
        pins_out_en |=> $stable(strap_q));

    // R6: test mode is sticky
    p_test_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        test_mode |=> test_mode);

    // R10: a low-power edge changes neither straps nor direction
    p_lp_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        low_power |=> ($stable(strap_q) && $stable(pins_out_en)));

    // R7: strap source follows the latch
    p_src_strap_r7: assert property (@(posedge clk) disable iff (rst)
        !reg_src |-> (freq_code == strap_q[FS_W-1:0]));
endmodule

bind strap_latch_ctrl strap_latch_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_src     (reg_src),
    .strap_q     (strap_q),
    .pins_out_en (pins_out_en),
    .freq_code   (freq_code),
    .test_mode   (test_mode),
    .low_power   (low_power)
);

// File: tb/strap_latch_ctrl_tb.sv
`timescale 1ns/1ps
module strap_latch_ctrl_tb;
    localparam int POR = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwrgd_n = 1'b1;
    logic       pdown = 1'b0;
    logic [4:0] strap_pins = '0;
    logic       reg_src = 1'b0;
    logic [2:0] reg_fs = '0;
    logic       reg_tbl = 1'b0;
    logic       reg_ss_a = 1'b0;
    logic       reg_ss_b = 1'b0;
    logic [4:0] strap_q;
    logic       pins_out_en;
    logic [2:0] freq_code;
    logic       table_sel;
    logic       test_mode;
    logic       spread_en;
    logic       low_power;

    int total = 0;
    int bad = 0;

    // {pins[4:0], reg_fs[2:0], reg_tbl}
    localparam logic [8:0] VEC [0:3] = '{
        9'b01101_010_0,
        9'b00011_110_1,
        9'b10110_001_1,
        9'b01000_111_0
    };

    strap_latch_ctrl #(.POR_CYCLES(POR)) u_dut (
        .clk(clk), .rst(rst), .pwrgd_n(pwrgd_n), .pdown(pdown),
        .strap_pins(strap_pins), .reg_src(reg_src), .reg_fs(reg_fs),
        .reg_tbl(reg_tbl), .reg_ss_a(reg_ss_a), .reg_ss_b(reg_ss_b),
        .strap_q(strap_q), .pins_out_en(pins_out_en), .freq_code(freq_code),
        .table_sel(table_sel), .test_mode(test_mode), .spread_en(spread_en),
        .low_power(low_power)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; pwrgd_n = 1'b1; pdown = 1'b0; reg_src = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    initial begin
        #(150000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        do_reset();
        // R1 reset state
        chk("R1 strap_q", 8'(strap_q), 8'h0);
        chk("R1 out_en", 8'(pins_out_en), 8'h0);
        chk("R1 test_mode", 8'(test_mode), 8'h0);
        chk("R1 freq_code", 8'(freq_code), 8'h0);
        chk("R1 low_power", 8'(low_power), 8'h0);

        // R2: no capture while power-good is inactive
        strap_pins = 5'b11111;
        tick(); tick(); tick();
        chk("R2 no capture before pg", 8'(strap_q), 8'h0);

        foreach (VEC[v]) begin
            logic [4:0] p;
            logic [2:0] rfs;
            logic       rtb;
            p   = VEC[v][8:4];
            rfs = VEC[v][3:1];
            rtb = VEC[v][0];
            do_reset();
            strap_pins = p;
            pwrgd_n = 1'b0;
            tick();                                    // capture edge
            chk("R2 capture", 8'(strap_q), 8'(p));
            chk("R5 fs field", 8'(freq_code), 8'(p[2:0]));
            chk("R5 table field", 8'(table_sel), 8'(p[3]));
            chk("R6 test field", 8'(test_mode), 8'(p[4]));
            chk("R3 not yet", 8'(pins_out_en), 8'h0);
            strap_pins = ~p;
            pwrgd_n = 1'b1;
            n = 0;
            for (int k = 1; k < POR; k++) begin
                tick();
                if (pins_out_en) n++;
            end
            chk("R3 early enable", 8'(n), 8'h0);
            tick();
            chk("R3 enable edge", 8'(pins_out_en), 8'h1);
            chk("R4 straps held", 8'(strap_q), 8'(p));
            reg_src = 1'b1; reg_fs = rfs; reg_tbl = rtb;
            #1;
            chk("R7 reg fs", 8'(freq_code), 8'(rfs));
            chk("R7 reg tbl", 8'(table_sel), 8'(rtb));
            for (int s = 0; s < 4; s++) begin
                reg_ss_a = s[0]; reg_ss_b = s[1];
                #1;
                chk("R8 spread", 8'(spread_en), 8'(s == 3));
            end
            tick();
            chk("R3 stays", 8'(pins_out_en), 8'h1);
        end

        // R9/R10: power-down during the count
        do_reset();
        strap_pins = 5'b00101;
        pwrgd_n = 1'b0;
        tick();
        tick(); tick(); tick();
        pdown = 1'b1;
        #1;
        chk("R9 async low_power", 8'(low_power), 8'h1);
        repeat (5) tick();
        pdown = 1'b0;
        tick();
        chk("R9 low_power clears", 8'(low_power), 8'h0);
        n = 1;
        while (!pins_out_en && n < 4 * POR) begin
            tick();
            n++;
        end
        chk("R10 stretched delay", 8'(n), 8'(POR - 2));
        chk("R4 straps after pd", 8'(strap_q), 8'h05);

        // R10: power-down on the capture edge defers the capture
        do_reset();
        strap_pins = 5'b01010;
        pdown = 1'b1;
        pwrgd_n = 1'b0;
        tick(); tick(); tick();
        chk("R10 no capture in pd", 8'(strap_q), 8'h0);
        pdown = 1'b0;
        tick();
        chk("R10 frozen release edge", 8'(strap_q), 8'h0);
        tick();
        chk("R2 capture after pd", 8'(strap_q), 8'h0a);

        // R6: sticky test mode
        do_reset();
        strap_pins = 5'b10001;
        pwrgd_n = 1'b0;
        tick();
        chk("R6 test set", 8'(test_mode), 8'h1);
        strap_pins = 5'b00000;
        pwrgd_n = 1'b1;
        repeat (POR + 2) tick();
        pdown = 1'b1;
        tick(); tick();
        pdown = 1'b0;
        tick(); tick();
        pwrgd_n = 1'b0;
        tick();
        chk("R6 test kept", 8'(test_mode), 8'h1);
        chk("R4 straps kept", 8'(strap_q), 8'h11);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R6 cleared by reset", 8'(test_mode), 8'h0);
        pwrgd_n = 1'b1;
        tick();
        chk("R1 out_en after reset", 8'(pins_out_en), 8'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule